// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block turns single requests from an on-chip bus into pin-level read and write cycles for asynchronous static RAM, with up to six banks each behind its own active-low chip select. A request carries a bank number, a byte address, a direction, byte enables, write data and a beat count. All memory pins are decoded from registered state and change only on the memory clock. Read data returns one beat at a time with a valid pulse. Completion is signalled by a done pulse, and a refused request by an error pulse.

Timing comes from a per-bank configuration word. That word sets the read latency, the write strobe width, the idle recovery after each access and a memory-type code. A bank only runs cycles when its type code marks it as SRAM. The data path is 16 or 32 bits wide, chosen by a parameter, with one byte mask per byte lane.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held and right after it, every chip select, output enable and write enable is high, `req_ready` is high and `resp_err`, `resp_done` and `rd_valid` are low.
- R2: A request to a bank whose type field (`bank_cfg[b]` bits 13:11) is not 3'b001, or to a bank number of NUM_BANKS or above, gives a one-clock `resp_err` pulse in the clock after the handshake. It asserts no chip select and gives no `resp_done`.
- R3: With read latency L (`bank_cfg[b]` bits 3:0), a read of N beats holds the chip select and output enable low without a break for (L+2)+(N-1)*(L+1) clocks. Beat 0 takes L+2 clocks and each later beat takes L+1. N is `req_beats`+1.
- R4: The value on `mem_din` in the last clock of each beat appears on `rd_data`, with `rd_valid` high for one clock, in the clock that follows. Beats are returned in order. `resp_done` is high in the clock after the chip select rises.
- R5: Through an access, `mem_addr` bits above bit 1 hold the request address. Bits 1:0 equal the request's low two bits plus the beat index, modulo 4.
- R6: While output enable is low, all byte masks `mem_bmask_n` are 0, `mem_rdwr` is 1 and the write data bus is not driven.
- R7: A write is a single beat whatever `req_beats` holds. With width W (`bank_cfg[b]` bits 7:4), the chip select is low for W+3 clocks and the write enable is low for W+1 clocks. The write enable starts one clock after the chip select falls and ends one clock before it rises. While it is low, `mem_dout_en` is 1, `mem_dout` carries the full write word and `mem_bmask_n` is the inverse of `req_be`.
- R8: With recovery R (`bank_cfg[b]` bits 10:8), `req_ready` stays low for exactly 2R+1 clocks after the chip select rises at the end of an access.
- R9: Output enable and write enable are never low together. `mem_rdwr` already has its final level in the clock before the chip select falls (1 for read, 0 for write).
- R10: At most one chip select is low at a time, and it is the one for the requested bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low reset |
| bank_cfg | input | NUM_BANKS x 14 | Per-bank timing and type words |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_bank | input | clog2(NUM_BANKS) | Target bank |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_beats | input | 2 | Read beats minus one |
| req_be | input | DATA_W/8 | Write byte enables |
| req_wdata | input | DATA_W | Write data |
| resp_err | output | 1 | Request refused |
| resp_done | output | 1 | Access finished |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | DATA_W | Read beat data |
| mem_cs_n | output | NUM_BANKS | Chip selects, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_rdwr | output | 1 | Direction, 1 for read |
| mem_bmask_n | output | DATA_W/8 | Byte masks, active low |
| mem_dout | output | DATA_W | Write data bus |
| mem_dout_en | output | 1 | Write data bus driven |
| mem_din | input | DATA_W | Read data bus |

## Verification
Reads run with latencies 0, 1, 2, 4 and 15 and with one to four beats, including a start address whose low bits wrap during the burst. This separates the longer first beat from the later ones and exposes any mistake in address stepping. The memory model returns a word that changes on every clock of a beat, so a sample taken one clock early or late gives a different value. Writes use strobe widths 0, 3 and 5 with sparse byte enables and a nonzero beat count, to check that the strobe sits inside the select and that the count is ignored. Recovery values 0, 1, 2, 3 and 7, together with refusals for a bad type and an out-of-range bank, show that recovery length and refusal each follow their own bank field.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
   localparam int RD_LAT_W = 4;
   localparam int WR_LEN_W = 4;
   localparam int RECOV_W  = 3;
   localparam int MTYPE_W  = 3;
   localparam int CFG_W    = RD_LAT_W + WR_LEN_W + RECOV_W + MTYPE_W;
   localparam logic [MTYPE_W-1:0] MTYPE_SRAM = 3'b001;

   typedef struct packed {
      logic [MTYPE_W-1:0]  mtype;
      logic [RECOV_W-1:0]  recov;
      logic [WR_LEN_W-1:0] wr_len;
      logic [RD_LAT_W-1:0] rd_lat;
   } bank_cfg_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SETUP, ST_READ, ST_WRITE, ST_RECOV
   } seq_state_t;
endpackage

// File: rtl/sram_bank_cfg_sel.sv
module sram_bank_cfg_sel
   import sram_seq_pkg::*;
#(
   parameter int NUM_BANKS = 6,
   localparam int BANK_W = $clog2(NUM_BANKS)
) (
   input  logic [NUM_BANKS-1:0][CFG_W-1:0] bank_cfg,
   input  logic [BANK_W-1:0]               bank,
   output bank_cfg_t                       sel,
   output logic                            ok
);
   bank_cfg_t cfg_arr [NUM_BANKS];
   logic      in_range;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_unpack
      assign cfg_arr[b] = bank_cfg_t'(bank_cfg[b]);
   end

   always_comb begin
      sel = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank == BANK_W'(b)) sel = cfg_arr[b];
      end
   end

   assign in_range = ({1'b0, bank} < (BANK_W+1)'(NUM_BANKS));
   assign ok       = in_range && (sel.mtype == MTYPE_SRAM);
endmodule

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             zero
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R3
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
   import sram_seq_pkg::*;
#(
   parameter int NUM_BANKS = 6,
   parameter int ADDR_W    = 26,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 5,
   localparam int BANK_W = $clog2(NUM_BANKS),
   localparam int BE_W   = DATA_W / 8
) (
   input  seq_state_t          state,
   input  logic [BANK_W-1:0]   bank,
   input  logic                rd,
   input  logic [BE_W-1:0]     be,
   input  logic [WR_LEN_W-1:0] wr_len,
   input  logic [CNT_W-1:0]    cnt,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [1:0]          beat,
   input  logic [DATA_W-1:0]   wdata,
   output logic [NUM_BANKS-1:0] cs_n,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                oe_n,
   output logic                we_n,
   output logic                rdwr,
   output logic [BE_W-1:0]     bmask_n,
   output logic [DATA_W-1:0]   dout,
   output logic                dout_en
);
   logic cs_phase, lane_phase, we_window;

   assign cs_phase   = (state == ST_READ) || (state == ST_WRITE);
   assign lane_phase = cs_phase || (state == ST_SETUP);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
      assign cs_n[b] = !(cs_phase && (bank == BANK_W'(b)));
   end

   assign we_window = (cnt != '0) && (cnt <= CNT_W'(wr_len) + CNT_W'(1));
   assign oe_n      = !(state == ST_READ);
   assign we_n      = !((state == ST_WRITE) && we_window);
   assign rdwr      = rd;
   assign mem_addr  = {addr[ADDR_W-1:2], addr[1:0] + beat};
   assign bmask_n   = lane_phase ? (rd ? '0 : ~be) : '1;
   assign dout      = wdata;
   assign dout_en   = !rd && ((state == ST_SETUP) || (state == ST_WRITE));
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int NUM_BANKS = 6,
   parameter int ADDR_W    = 26,
   parameter int DATA_W    = 32,
   localparam int BANK_W = $clog2(NUM_BANKS),
   localparam int BE_W   = DATA_W / 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_BANKS-1:0][CFG_W-1:0] bank_cfg,
   input  logic                           req_valid,
   output logic                           req_ready,
   input  logic [BANK_W-1:0]              req_bank,
   input  logic [ADDR_W-1:0]              req_addr,
   input  logic                           req_write,
   input  logic [1:0]                     req_beats,
   input  logic [BE_W-1:0]                req_be,
   input  logic [DATA_W-1:0]              req_wdata,
   output logic                           resp_err,
   output logic                           resp_done,
   output logic                           rd_valid,
   output logic [DATA_W-1:0]              rd_data,
   output logic [NUM_BANKS-1:0]           mem_cs_n,
   output logic [ADDR_W-1:0]              mem_addr,
   output logic                           mem_oe_n,
   output logic                           mem_we_n,
   output logic                           mem_rdwr,
   output logic [BE_W-1:0]                mem_bmask_n,
   output logic [DATA_W-1:0]              mem_dout,
   output logic                           mem_dout_en,
   input  logic [DATA_W-1:0]              mem_din
);
   localparam int MAX_W = (RD_LAT_W > WR_LEN_W) ? RD_LAT_W : WR_LEN_W;
   localparam int CNT_W = ((MAX_W > RECOV_W + 1) ? MAX_W : RECOV_W + 1) + 1;

   if (DATA_W != 16 && DATA_W != 32) begin : g_bad_width
      $error("sram_seq_ctrl: DATA_W must be 16 or 32");
   end
   if (NUM_BANKS < 2 || NUM_BANKS > 8) begin : g_bad_banks
      $error("sram_seq_ctrl: NUM_BANKS must be 2 to 8");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("sram_seq_ctrl: ADDR_W must be at least 3");
   end

   seq_state_t          state_q;
   logic [BANK_W-1:0]   bank_q;
   logic [ADDR_W-1:0]   addr_q;
   logic                rd_q;
   logic [BE_W-1:0]     be_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [1:0]          beats_q, beat_q;
   logic [RD_LAT_W-1:0] rd_lat_q;
   logic [WR_LEN_W-1:0] wr_len_q;
   logic [RECOV_W-1:0]  recov_q;

   bank_cfg_t        cfg_req;
   logic             cfg_ok;
   logic             tmr_load, tmr_zero, last_beat;
   logic [CNT_W-1:0] tmr_val, tmr_cnt, recov_val;

   sram_bank_cfg_sel #(.NUM_BANKS(NUM_BANKS)) i_cfg_sel (
      .bank_cfg (bank_cfg),
      .bank     (req_bank),
      .sel      (cfg_req),
      .ok       (cfg_ok)
   );

   sram_cycle_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .cnt      (tmr_cnt),
      .zero     (tmr_zero)
   );

   assign last_beat = (beat_q == beats_q);
   assign recov_val = CNT_W'({recov_q, 1'b0});
   assign req_ready = (state_q == ST_IDLE);

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_SETUP: begin
            tmr_load = 1'b1;
            tmr_val  = rd_q ? CNT_W'(rd_lat_q) + CNT_W'(1) : CNT_W'(wr_len_q) + CNT_W'(2);
         end
         ST_READ: if (tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = last_beat ? recov_val : CNT_W'(rd_lat_q);
         end
         ST_WRITE: if (tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = recov_val;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bank_q    <= '0;
         addr_q    <= '0;
         rd_q      <= 1'b1;
         be_q      <= '0;
         wdata_q   <= '0;
         beats_q   <= '0;
         beat_q    <= '0;
         rd_lat_q  <= '0;
         wr_len_q  <= '0;
         recov_q   <= '0;
         resp_err  <= 1'b0;
         resp_done <= 1'b0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
      end else begin
         resp_err  <= 1'b0;
         resp_done <= 1'b0;
         rd_valid  <= 1'b0;
         case (state_q)
            ST_IDLE: if (req_valid) begin
               if (cfg_ok) begin
                  state_q  <= ST_SETUP;
                  bank_q   <= req_bank;
                  addr_q   <= req_addr;
                  rd_q     <= !req_write;
                  be_q     <= req_be;
                  wdata_q  <= req_wdata;
                  beats_q  <= req_write ? 2'd0 : req_beats;
                  beat_q   <= '0;
                  rd_lat_q <= cfg_req.rd_lat;
                  wr_len_q <= cfg_req.wr_len;
                  recov_q  <= cfg_req.recov;
               end else begin
                  resp_err <= 1'b1;
               end
            end
            ST_SETUP: state_q <= rd_q ? ST_READ : ST_WRITE;
            ST_READ: if (tmr_zero) begin
               rd_valid <= 1'b1;
               rd_data  <= mem_din;
               if (last_beat) begin
                  state_q   <= ST_RECOV;
                  resp_done <= 1'b1;
               end else begin
                  beat_q <= beat_q + 1'b1;
               end
            end
            ST_WRITE: if (tmr_zero) begin
               state_q   <= ST_RECOV;
               resp_done <= 1'b1;
            end
            ST_RECOV: if (tmr_zero) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   sram_pin_drive #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W)
   ) i_pins (
      .state    (state_q),
      .bank     (bank_q),
      .rd       (rd_q),
      .be       (be_q),
      .wr_len   (wr_len_q),
      .cnt      (tmr_cnt),
      .addr     (addr_q),
      .beat     (beat_q),
      .wdata    (wdata_q),
      .cs_n     (mem_cs_n),
      .mem_addr (mem_addr),
      .oe_n     (mem_oe_n),
      .we_n     (mem_we_n),
      .rdwr     (mem_rdwr),
      .bmask_n  (mem_bmask_n),
      .dout     (mem_dout),
      .dout_en  (mem_dout_en)
   );

   logic cs_any;
   assign cs_any = !(&mem_cs_n);

   AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n)); // R9
   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n)); // R10
   AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_bmask_n == '0 && mem_rdwr && !mem_dout_en)); // R6
   AST_WE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(cs_any)); // R7
   AST_WE_BEFORE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> cs_any); // R7
   AST_WR_FULL_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dout_en); // R7
   AST_DIR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_any && !$past(cs_any)) |-> $stable(mem_rdwr)); // R9
   AST_UPPER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_any && $past(cs_any)) |-> $stable(mem_addr[ADDR_W-1:2])); // R5
   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      resp_err |-> (!cs_any && !resp_done)); // R2
   AST_RECOV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_any) |-> (!req_ready && resp_done)); // R8
endmodule

// File: tb/test_sram_seq_ctrl.sv
`timescale 1ns/1ps
module test_sram_seq_ctrl;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [5:0][13:0]  bank_cfg;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [2:0]        req_bank = '0;
   logic [25:0]       req_addr = '0;
   logic              req_write = 1'b0;
   logic [1:0]        req_beats = '0;
   logic [3:0]        req_be = '0;
   logic [31:0]       req_wdata = '0;
   logic              resp_err, resp_done, rd_valid;
   logic [31:0]       rd_data;
   logic [5:0]        mem_cs_n;
   logic [25:0]       mem_addr;
   logic              mem_oe_n, mem_we_n, mem_rdwr, mem_dout_en;
   logic [3:0]        mem_bmask_n;
   logic [31:0]       mem_dout, mem_din;

   int checks = 0;
   int bad = 0;
   bit finished = 0;
   logic [31:0] exp_q[$];

   always #2 clk = ~clk;

   sram_seq_ctrl i_sram_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .bank_cfg(bank_cfg),
      .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
      .req_addr(req_addr), .req_write(req_write), .req_beats(req_beats),
      .req_be(req_be), .req_wdata(req_wdata),
      .resp_err(resp_err), .resp_done(resp_done), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_rdwr(mem_rdwr), .mem_bmask_n(mem_bmask_n), .mem_dout(mem_dout),
      .mem_dout_en(mem_dout_en), .mem_din(mem_din)
   );

   // memory model: word depends on address and on clocks spent at that address
   int          age = 0;
   bit          prev_oe = 0;
   logic [25:0] prev_addr = '0;
   always @(negedge clk) begin
      if (!mem_oe_n && prev_oe && mem_addr == prev_addr) age <= age + 1;
      else age <= 0;
      prev_oe   <= !mem_oe_n;
      prev_addr <= mem_addr;
   end
   assign mem_din = {6'h2D, mem_addr} + 32'(age);

   task automatic check_eq(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: compare each returned beat with the queued expectation
   always @(negedge clk) begin
      if (rst_n && rd_valid && !finished) begin
         if (exp_q.size() == 0) check_eq("R4", "unexpected rd_valid", 1, 0);
         else check_eq("R4", "rd_data", rd_data, exp_q.pop_front());
      end
   end

   function automatic logic [13:0] mk_cfg(input logic [2:0] mt, input logic [2:0] rc,
                                          input logic [3:0] wl, input logic [3:0] rl);
      return {mt, rc, wl, rl};
   endfunction

   task automatic run_access(input int bank, input logic [25:0] addr, input bit wr,
                             input int beats, input logic [3:0] be, input logic [31:0] wd,
                             input int rdf, input int rdn, input int rrr);
      int cs_len = 0, oe_len = 0, we_len = 0, we_first = -1, we_last = -1, recov = 0;
      int beat_idx, exp_cs;
      bit seen_cs = 0, bad_bank = 0, bad_addr = 0, bad_rd = 0, bad_wr = 0, done_ok = 0, dir_ok;
      if (!wr) begin
         for (int k = 0; k < beats; k++) begin
            logic [25:0] a;
            a = {addr[25:2], addr[1:0] + 2'(k)};
            exp_q.push_back({6'h2D, a} + 32'((k == 0) ? rdf + 1 : rdf));
         end
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_bank = 3'(bank); req_addr = addr; req_write = wr;
      req_beats = 2'(beats - 1); req_be = be; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      dir_ok = (mem_rdwr == !wr) && (mem_cs_n == 6'h3F);
      for (int cyc = 0; cyc < 400; cyc++) begin
         @(negedge clk);
         if (mem_cs_n != 6'h3F) begin
            if (mem_cs_n != ~(6'b1 << bank)) bad_bank = 1;
            if (wr || cs_len < rdf + 2) beat_idx = 0;
            else beat_idx = 1 + (cs_len - (rdf + 2)) / (rdf + 1);
            if (mem_addr != {addr[25:2], addr[1:0] + 2'(beat_idx)}) bad_addr = 1;
            if (!mem_oe_n) begin
               oe_len++;
               if (mem_bmask_n != 4'b0000 || !mem_rdwr || mem_dout_en) bad_rd = 1;
            end
            if (!mem_we_n) begin
               we_len++;
               if (we_first < 0) we_first = cs_len;
               we_last = cs_len;
               if (!mem_dout_en || mem_dout != wd || mem_bmask_n != ~be || mem_rdwr) bad_wr = 1;
            end
            cs_len++;
            seen_cs = 1;
         end else if (seen_cs) begin
            if (recov == 0 && resp_done) done_ok = 1;
            if (req_ready) break;
            recov++;
         end
      end
      exp_cs = wr ? rdn + 3 : (rdf + 2) + (beats - 1) * (rdf + 1);
      check_eq("R9", "direction set before select", dir_ok, 1);
      check_eq("R10", "select matches bank", bad_bank, 0);
      check_eq("R5", "address stepping", bad_addr, 0);
      check_eq(wr ? "R7" : "R3", "select length", cs_len, exp_cs);
      check_eq(wr ? "R9" : "R3", "output enable length", oe_len, wr ? 0 : exp_cs);
      check_eq("R8", "recovery clocks", recov, 2 * rrr + 1);
      check_eq(wr ? "R7" : "R4", "done after select", done_ok, 1);
      if (wr) begin
         check_eq("R7", "write strobe length", we_len, rdn + 1);
         check_eq("R7", "strobe starts one clock in", we_first, 1);
         check_eq("R7", "strobe ends one clock early", we_last, rdn + 1);
         check_eq("R7", "write pins", bad_wr, 0);
      end else begin
         check_eq("R6", "read pins", bad_rd, 0);
         check_eq("R9", "no strobe on read", we_len, 0);
      end
   endtask

   task automatic run_reject(input int bank);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_bank = 3'(bank); req_write = 1'b0; req_beats = 2'd0;
      @(negedge clk);
      req_valid = 1'b0;
      check_eq("R2", "error pulse", resp_err, 1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check_eq("R2", "no select after refusal", mem_cs_n, 6'h3F);
         check_eq("R2", "no done after refusal", resp_done, 0);
         check_eq("R2", "error is one clock", resp_err, 0);
      end
   endtask

   task automatic finish_run();
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         checks++;
         bad++;
         $display("FAIL watchdog expired act=1 exp=0");
         finish_run();
      end
   end

   initial begin
      bank_cfg[0] = mk_cfg(3'b001, 3'd1, 4'd0, 4'd4);
      bank_cfg[1] = mk_cfg(3'b001, 3'd0, 4'd3, 4'd0);
      bank_cfg[2] = mk_cfg(3'b001, 3'd2, 4'd5, 4'd2);
      bank_cfg[3] = mk_cfg(3'b001, 3'd7, 4'd15, 4'd15);
      bank_cfg[4] = mk_cfg(3'b001, 3'd3, 4'd5, 4'd1);
      bank_cfg[5] = mk_cfg(3'b010, 3'd0, 4'd0, 4'd0);
      repeat (3) @(negedge clk);
      check_eq("R1", "selects in reset", mem_cs_n, 6'h3F);
      check_eq("R1", "strobes in reset", {mem_oe_n, mem_we_n}, 2'b11);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1", "ready after reset", req_ready, 1);
      check_eq("R1", "pulses after reset", {resp_err, resp_done, rd_valid}, 3'b000);
      check_eq("R1", "selects after reset", mem_cs_n, 6'h3F);

      run_access(0, 26'h1234560, 0, 4, 4'h0, 32'h0, 4, 0, 1);
      run_access(1, 26'h0ABCDE1, 0, 1, 4'h0, 32'h0, 0, 3, 0);
      run_access(2, 26'h3FFFFFE, 0, 3, 4'h0, 32'h0, 2, 5, 2);
      run_access(3, 26'h0000003, 0, 2, 4'h0, 32'h0, 15, 15, 7);
      run_access(0, 26'h0010004, 1, 1, 4'hF, 32'hCAFE_F00D, 4, 0, 1);
      run_access(4, 26'h2222222, 1, 4, 4'b0101, 32'h1357_9BDF, 1, 5, 3);
      run_access(1, 26'h0000100, 1, 1, 4'b1000, 32'hA5A5_5A5A, 0, 3, 0);
      run_reject(5);
      run_reject(6);
      run_access(4, 26'h1111111, 0, 4, 4'h0, 32'h0, 1, 5, 3);

      repeat (4) @(negedge clk);
      check_eq("R4", "all beats returned", exp_q.size(), 0);
      finish_run();
   end
endmodule